// File: doc/BRIEF.md
# Variable-Divisor Modulo Reduction Pipeline

This block returns the remainder of an unsigned dividend divided by an unsigned divisor, where both operands arrive together with a request strobe and the divisor may differ on every request. The remainder is found by a chain of conditional subtractions. Each step removes the divisor scaled by a power of two whenever that scaled value does not exceed what is left. This lowers the magnitude of the working value and never changes its residue. After one step for every shift from DATA_W-1 down to 0, the working value is the remainder.

A build parameter selects the datapath. In the pipelined variant, every subtraction step sits behind a register and the divisor travels with its own operand, so a new pair can be issued on every clock and each result appears a fixed number of cycles later. In the combinational variant, the whole chain settles within one cycle. Both variants register the result and use the same ports. A divisor of zero returns the dividend unchanged. A valid flag travels beside each operand pair, so an idle cycle at the input shows up as an idle cycle at the output.

Top module: `vmod_pipe`

## Requirements
- R1: For every accepted pair with a nonzero divisor, `remainder_o` equals `dividend_i mod divisor_i`, interpreted as unsigned DATA_W-bit integers.
- R2: For an accepted pair whose divisor is zero, `remainder_o` equals the dividend, and `res_valid_o` is still asserted for that result.
- R3: With PIPELINED=1, the result of a pair accepted at clock edge k is presented, with `res_valid_o` high, during the cycle after edge k+DATA_W+1 (DATA_W+2 edges in total). `res_valid_o` is never high at any other time.
- R4: A new pair can be accepted on every clock. Back-to-back pairs with different divisors each produce their own correct remainder, in the order they were issued.
- R5: With PIPELINED=0, the result of a pair accepted at edge k is presented, with `res_valid_o` high, in the cycle right after edge k, and the same ports are used.
- R6: Raising `rst_i` clears `res_valid_o`, `remainder_o` and `accept_rdy_o` at once, without waiting for a clock edge. `accept_rdy_o` rises on the first clock edge after reset is released and then stays high.
- R7: A cycle with `req_valid_i` low produces a cycle with `res_valid_o` low at the same output position, so gaps in the input stream are preserved.
- R8: Boundary operands are handled: a dividend below the divisor returns the dividend, a divisor of one returns zero, equal operands return zero, and the all-ones dividend is reduced correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| req_valid_i | input | 1 | Operand pair valid; taken when `accept_rdy_o` is high |
| dividend_i | input | DATA_W | Unsigned dividend |
| divisor_i | input | DATA_W | Unsigned divisor, may change every request |
| remainder_o | output | DATA_W | Registered remainder |
| res_valid_o | output | 1 | Remainder on `remainder_o` is valid this cycle |
| accept_rdy_o | output | 1 | Block takes requests (high from the first edge after reset) |

## Verification
The assertions assume that operand pairs are offered only while `accept_rdy_o` is high, and that the dividend and divisor are stable and known at the sampling edge whenever `req_valid_i` is high. They also take reset as the only way to discard transactions in flight. The stimulus keeps `req_valid_i` low during reset and for two cycles after each release. It changes all inputs on the falling edge only. It draws divisors from a mix that favours small values, includes zero and full-scale values, and changes the divisor on every cycle of the back-to-back runs.

// File: rtl/vmod_pkg.sv
package vmod_pkg;

   // Cycles from operand capture to a valid result at the output port.
   function automatic int unsigned vmod_latency(input int unsigned width, input bit piped);
      return piped ? (width + 2) : 1;
   endfunction

endpackage

// File: rtl/vmod_reg.sv
module vmod_reg #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             v_in,
   input  logic [WIDTH-1:0] d_in,
   output logic             v_out,
   output logic [WIDTH-1:0] d_out
);

   if (WIDTH < 1) begin : g_bad_width
      $error("vmod_reg: WIDTH must be at least 1");
   end

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         v_out <= 1'b0;
         d_out <= '0;
      end else begin
         v_out <= v_in;
         d_out <= d_in;
      end
   end

endmodule

// File: rtl/vmod_stage.sv
module vmod_stage #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned SHIFT  = 0,
   parameter bit          REG    = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              v_in,
   input  logic [DATA_W-1:0] r_in,
   input  logic [DATA_W-1:0] z_in,
   output logic              v_out,
   output logic [DATA_W-1:0] r_out,
   output logic [DATA_W-1:0] z_out
);

   localparam int unsigned WIDE_W = 2 * DATA_W;

   if (SHIFT >= DATA_W) begin : g_bad_shift
      $error("vmod_stage: SHIFT must be below DATA_W");
   end

   logic [WIDE_W-1:0] zs_w;
   logic [WIDE_W-1:0] r_w;
   logic              take;
   logic [DATA_W-1:0] r_nx;

   // Wide compare: the scaled divisor can exceed DATA_W bits.
   assign zs_w = {{DATA_W{1'b0}}, z_in} << SHIFT;
   assign r_w  = {{DATA_W{1'b0}}, r_in};
   assign take = (zs_w <= r_w);
   assign r_nx = take ? (r_in - zs_w[DATA_W-1:0]) : r_in;

   if (REG) begin : g_reg
      always_ff @(posedge clk_i or posedge rst_i) begin
         if (rst_i) begin
            v_out <= 1'b0;
            r_out <= '0;
            z_out <= '0;
         end else begin
            v_out <= v_in;
            r_out <= r_nx;
            z_out <= z_in;
         end
      end
   end else begin : g_comb
      assign v_out = v_in;
      assign r_out = r_nx;
      assign z_out = z_in;
   end

endmodule

// File: rtl/vmod_pipe.sv
module vmod_pipe #(
   parameter int unsigned DATA_W    = 8,
   parameter bit          PIPELINED = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              req_valid_i,
   input  logic [DATA_W-1:0] dividend_i,
   input  logic [DATA_W-1:0] divisor_i,
   output logic [DATA_W-1:0] remainder_o,
   output logic              res_valid_o,
   output logic              accept_rdy_o
);

   localparam int unsigned PAIR_W = 2 * DATA_W;

   if (DATA_W < 2 || DATA_W > 64) begin : g_bad_width
      $error("vmod_pipe: DATA_W must lie in 2..64");
   end

   logic              rdy_q;
   logic              accept;
   logic              h_v;
   logic [DATA_W-1:0] h_x;
   logic [DATA_W-1:0] h_z;

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) rdy_q <= 1'b0;
      else       rdy_q <= 1'b1;
   end

   assign accept       = req_valid_i & rdy_q;
   assign accept_rdy_o = rdy_q;

   // Capture stage: registered only in the pipelined build.
   if (PIPELINED) begin : g_cap_reg
      logic [PAIR_W-1:0] cap_d;
      vmod_reg #(.WIDTH(PAIR_W)) u_cap (
         .clk_i (clk_i),
         .rst_i (rst_i),
         .v_in  (accept),
         .d_in  ({divisor_i, dividend_i}),
         .v_out (h_v),
         .d_out (cap_d)
      );
      assign h_x = cap_d[DATA_W-1:0];
      assign h_z = cap_d[PAIR_W-1:DATA_W];
   end else begin : g_cap_comb
      assign h_v = accept;
      assign h_x = dividend_i;
      assign h_z = divisor_i;
   end

   logic              s_v [0:DATA_W];
   logic [DATA_W-1:0] s_r [0:DATA_W];
   logic [DATA_W-1:0] s_z [0:DATA_W-1];
   logic [DATA_W-1:0] z_unused;

   assign s_v[0] = h_v;
   assign s_r[0] = h_x;
   assign s_z[0] = h_z;

   // Stage k removes the divisor scaled by 2**(DATA_W-1-k).
   for (genvar k = 0; k < DATA_W; k++) begin : g_stage
      if (k == DATA_W - 1) begin : g_last
         vmod_stage #(.DATA_W(DATA_W), .SHIFT(DATA_W-1-k), .REG(PIPELINED)) u_stg (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .v_in  (s_v[k]),
            .r_in  (s_r[k]),
            .z_in  (s_z[k]),
            .v_out (s_v[k+1]),
            .r_out (s_r[k+1]),
            .z_out (z_unused)
         );
      end else begin : g_mid
         vmod_stage #(.DATA_W(DATA_W), .SHIFT(DATA_W-1-k), .REG(PIPELINED)) u_stg (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .v_in  (s_v[k]),
            .r_in  (s_r[k]),
            .z_in  (s_z[k]),
            .v_out (s_v[k+1]),
            .r_out (s_r[k+1]),
            .z_out (s_z[k+1])
         );
      end
   end

   vmod_reg #(.WIDTH(DATA_W)) u_out (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .v_in  (s_v[DATA_W]),
      .d_in  (s_r[DATA_W]),
      .v_out (res_valid_o),
      .d_out (remainder_o)
   );

endmodule

// File: rtl/vmod_chk.sv
module vmod_chk #(
   parameter int unsigned DATA_W    = 8,
   parameter bit          PIPELINED = 1'b1
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              req_valid_i,
   input logic [DATA_W-1:0] dividend_i,
   input logic [DATA_W-1:0] divisor_i,
   input logic [DATA_W-1:0] remainder_o,
   input logic              res_valid_o,
   input logic              accept_rdy_o
);

   localparam int unsigned LAT = vmod_pkg::vmod_latency(DATA_W, PIPELINED);

   logic              sv [0:LAT-1];
   logic [DATA_W-1:0] sx [0:LAT-1];
   logic [DATA_W-1:0] sz [0:LAT-1];

   // Shadow of accepted operands, aligned with the output port.
   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         for (int i = 0; i < LAT; i++) begin
            sv[i] <= 1'b0;
            sx[i] <= '0;
            sz[i] <= '0;
         end
      end else begin
         sv[0] <= req_valid_i && accept_rdy_o;
         sx[0] <= dividend_i;
         sz[0] <= divisor_i;
         for (int i = 1; i < LAT; i++) begin
            sv[i] <= sv[i-1];
            sx[i] <= sx[i-1];
            sz[i] <= sz[i-1];
         end
      end
   end

   p_done_latency_r3_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      res_valid_o == sv[LAT-1]);

   p_rem_below_div_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      (res_valid_o && sz[LAT-1] != '0) |-> (remainder_o < sz[LAT-1]));

   p_rem_congruent_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      (res_valid_o && sz[LAT-1] != '0) |->
         (remainder_o <= sx[LAT-1] && ((sx[LAT-1] - remainder_o) % sz[LAT-1]) == '0));

   p_zero_div_echo_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (res_valid_o && sz[LAT-1] == '0) |-> (remainder_o == sx[LAT-1]));

   p_ready_sticky_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      accept_rdy_o |=> accept_rdy_o);

endmodule

bind vmod_pipe vmod_chk #(.DATA_W(DATA_W), .PIPELINED(PIPELINED)) u_chk (
   .clk_i        (clk_i),
   .rst_i        (rst_i),
   .req_valid_i  (req_valid_i),
   .dividend_i   (dividend_i),
   .divisor_i    (divisor_i),
   .remainder_o  (remainder_o),
   .res_valid_o  (res_valid_o),
   .accept_rdy_o (accept_rdy_o)
);

// File: tb/vmod_pipe_tb_top.sv
module vmod_pipe_tb_top;

   localparam int N  = 8;
   localparam int LP = N + 2;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         req = 1'b0;
   logic [N-1:0] xin = '0;
   logic [N-1:0] zin = '0;

   logic [N-1:0] y_p, y_c;
   logic         v_p, v_c, r_p, r_c;

   int    checks   = 0;
   int    failures = 0;
   bit    run_cmp  = 1'b0;
   string tag      = "R1";

   always #4 clk = ~clk;

   vmod_pipe #(.DATA_W(N), .PIPELINED(1'b1)) dut_i (
      .clk_i(clk), .rst_i(rst), .req_valid_i(req), .dividend_i(xin), .divisor_i(zin),
      .remainder_o(y_p), .res_valid_o(v_p), .accept_rdy_o(r_p));

   vmod_pipe #(.DATA_W(N), .PIPELINED(1'b0)) dut_c_i (
      .clk_i(clk), .rst_i(rst), .req_valid_i(req), .dividend_i(xin), .divisor_i(zin),
      .remainder_o(y_c), .res_valid_o(v_c), .accept_rdy_o(r_c));

   function automatic logic [N-1:0] ref_mod(input logic [N-1:0] a, input logic [N-1:0] b);
      return (b == '0) ? a : (a % b);
   endfunction

   task automatic check(input bit ok, input string rq, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   // Expected output positions: index LP-1 (pipelined) and the single comb slot.
   logic         mv [0:LP-1];
   logic [N-1:0] my [0:LP-1];
   logic         mvc;
   logic [N-1:0] myc;

   always @(posedge clk or posedge rst) begin
      if (rst) begin
         for (int i = 0; i < LP; i++) begin mv[i] <= 1'b0; my[i] <= '0; end
         mvc <= 1'b0; myc <= '0;
      end else begin
         mv[0] <= req && r_p;
         my[0] <= ref_mod(xin, zin);
         for (int i = 1; i < LP; i++) begin mv[i] <= mv[i-1]; my[i] <= my[i-1]; end
         mvc <= req && r_c;
         myc <= ref_mod(xin, zin);
      end
   end

   always @(negedge clk) begin
      if (run_cmp && !rst) begin
         check(v_p == mv[LP-1], tag, "pipelined valid", v_p, mv[LP-1]);
         if (mv[LP-1]) check(y_p == my[LP-1], tag, "pipelined remainder", y_p, my[LP-1]);
         check(v_c == mvc, "R5", "comb valid", v_c, mvc);
         if (mvc) check(y_c == myc, "R5", "comb remainder", y_c, myc);
      end
   end

   task automatic send(input bit v, input logic [N-1:0] a, input logic [N-1:0] b);
      @(negedge clk);
      req = v; xin = a; zin = b;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) send(1'b0, '0, '0);
   endtask

   function automatic logic [N-1:0] pick_div();
      int sel;
      sel = $urandom_range(0, 7);
      if (sel == 0) return '0;
      if (sel < 4)  return N'($urandom_range(1, 15));
      return N'($urandom_range(0, (1 << N) - 1));
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      // R6: state during reset
      #1;
      check(v_p == 1'b0 && v_c == 1'b0, "R6", "valid in reset", {v_p, v_c}, 0);
      check(r_p == 1'b0 && r_c == 1'b0, "R6", "ready in reset", {r_p, r_c}, 0);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(r_p && r_c, "R6", "ready after release", {r_p, r_c}, 3);
      run_cmp = 1'b1;
      @(negedge clk);

      // R3: single request then exact latency window
      tag = "R3";
      send(1'b1, 8'd200, 8'd7);
      idle(LP + 3);

      // R8: boundary operands
      tag = "R8";
      send(1'b1, 8'd5,   8'd9);
      send(1'b1, 8'd255, 8'd1);
      send(1'b1, 8'd255, 8'd255);
      send(1'b1, 8'd0,   8'd3);
      send(1'b1, 8'd255, 8'd254);
      send(1'b1, 8'd128, 8'd128);
      send(1'b1, 8'd255, 8'd128);
      idle(LP + 1);

      // R2: zero divisor echoes dividend
      tag = "R2";
      send(1'b1, 8'd77,  8'd0);
      send(1'b1, 8'd0,   8'd0);
      send(1'b1, 8'd255, 8'd0);
      idle(LP + 1);

      // R4: back-to-back, divisor changes each cycle
      tag = "R4";
      for (int i = 0; i < 400; i++) send(1'b1, N'($urandom_range(0, 255)), pick_div());
      idle(LP + 1);

      // R7: gaps in the stream
      tag = "R7";
      for (int i = 0; i < 400; i++)
         send(1'($urandom_range(0, 1)), N'($urandom_range(0, 255)), pick_div());
      idle(LP + 1);

      // R1: general random traffic
      tag = "R1";
      for (int i = 0; i < 1500; i++)
         send(1'($urandom_range(0, 3) != 0), N'($urandom_range(0, 255)), pick_div());

      // R6: asynchronous reset while results are in flight
      @(negedge clk);
      #2 rst = 1'b1;
      req = 1'b0;
      #1;
      check(v_p == 1'b0 && v_c == 1'b0, "R6", "valid cleared without edge", {v_p, v_c}, 0);
      check(y_p == '0 && y_c == '0, "R6", "remainder cleared without edge", {y_p, y_c}, 0);
      check(r_p == 1'b0 && r_c == 1'b0, "R6", "ready cleared without edge", {r_p, r_c}, 0);
      @(negedge clk);
      rst = 1'b0;
      tag = "R6";
      idle(2);
      check(r_p && r_c, "R6", "ready after second release", {r_p, r_c}, 3);
      tag = "R1";
      for (int i = 0; i < 100; i++) send(1'b1, N'($urandom_range(0, 255)), pick_div());
      idle(LP + 2);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule